// File: doc/BRIEF.md
# Host Command Vector Handshake Register

This block is a small register through which an external host asks a processor core to run a chosen interrupt routine. The register is one byte wide. The top bit is a request flag. The lower seven bits hold a vector number. When the host writes the byte with the top bit set, the block raises a request line and a pending flag toward the core. It also drives the routine's start address, which is the vector number doubled.

When the core takes the interrupt, it pulses an acknowledge input for one cycle. The hardware then clears the request flag. The host polls the flag through its read port to learn that the command was accepted. While a command is outstanding, the host must leave the register alone. If the host writes anyway, the write is dropped and a sticky error bit is set. Only a dedicated clear strobe removes that bit.

Four reset sources return the block to its idle state: the hardware reset and three strobes for software, individual and stop resets. After any of them the vector number is 0x32 and the routine address is 0x064. All logic runs on one clock, and every reset is synchronous.

Top module: `hcv_top`

## Requirements
- R1: A read returns the request flag in bit 7 and the 7-bit vector number in bits 6..0.
- R2: A write made while no command is outstanding, with bit 7 = 1, sets the request flag. From the next cycle, both `core_req` and `core_pend` are 1.
- R3: A `core_ack` pulse while the flag is set clears the flag in the next cycle. After that, a host read shows bit 7 = 0.
- R4: `core_vec_addr` always equals twice the stored vector number: the number in bits 7..1 and 0 in bit 0.
- R5: One write sets the request flag and loads the vector number together. The new vector appears on `core_vec_addr` in the same cycle as the request.
- R6: Any one of `rst_n` = 0, `sw_rst`, `ind_rst` or `stop_rst` = 1 at a clock edge has the same effect. The vector number becomes 0x32, the request flag becomes 0, the error bit becomes 0, and `core_vec_addr` becomes 0x64.
- R7: A write made while the flag is set changes neither the flag nor the vector number, and it sets `ovr_err` from the next cycle.
- R8: `ovr_err` stays 1 until `ovr_clr` is pulsed. If a new overrun and `ovr_clr` fall in the same cycle, the error bit stays 1.
- R9: A `core_ack` pulse while no command is outstanding changes nothing visible.
- R10: A write made while no command is outstanding, with bit 7 = 0, updates only the vector number and raises no request.
- R11: Suppose a host write and `core_ack` arrive in the same cycle while the flag is set. The write is judged against the flag as it was before that edge, so it is dropped and flagged as an overrun. The acknowledge still clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, synchronous, active low |
| sw_rst | input | 1 | Software reset strobe, active high |
| ind_rst | input | 1 | Individual reset strobe, active high |
| stop_rst | input | 1 | Stop reset strobe, active high |
| host_wr_en | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data: bit 7 request, bits 6..0 vector |
| host_rdata | output | 8 | Host read data: bit 7 request, bits 6..0 vector |
| ovr_err | output | 1 | Sticky error: a write arrived while a command was outstanding |
| ovr_clr | input | 1 | Clears `ovr_err` |
| core_req | output | 1 | Interrupt request toward the core |
| core_pend | output | 1 | Command pending status toward the core |
| core_vec_addr | output | 8 | Interrupt routine start address (2 x vector) |
| core_ack | input | 1 | Single-cycle acknowledge from the core |

## Verification
The interesting collision is a host write landing in the same cycle as the core's acknowledge of the outstanding command. The bench provokes it by holding a pending command and then driving `host_wr_en` and `core_ack` for the same clock. The expected result is a cleared flag, an unchanged vector and a raised error bit (R11). The bench also makes an overrun and `ovr_clr` coincide, to judge which one wins on the error bit (R8). Beyond these two cases, all 128 vector numbers are swept through the full handshake.

// File: rtl/hcv_pkg.sv
// Package: shared defaults for the host command vector register.
// Assumes: the vector field is narrower than the host data byte by one bit.
package hcv_pkg;
    localparam int          HCV_VEC_W_DEF = 7;
    localparam logic [6:0]  HCV_RST_VEC_DEF = 7'h32;
endpackage

// File: rtl/hcv_rst_merge.sv
// Module: folds the four reset sources into one active-high synchronous reset.
// Assumes: every source is synchronous to clk; the hardware reset is active low.
module hcv_rst_merge (
    input  logic rst_n,
    input  logic sw_rst,
    input  logic ind_rst,
    input  logic stop_rst,
    output logic rst_any
);
    // Purpose: any single source resets the whole block.
    always_comb begin
        rst_any = !rst_n || sw_rst || ind_rst || stop_rst;
    end
endmodule

// File: rtl/hcv_overrun.sv
// Module: accepts or drops host writes and keeps the sticky overrun error.
// Assumes: req_flag is the registered request flag (value before this edge).
module hcv_overrun (
    input  logic clk,
    input  logic rst_any,
    input  logic wr_en,
    input  logic req_flag,
    input  logic clr,
    output logic wr_accept,
    output logic ovr
);
    logic wr_blocked;

    // Purpose: a write is taken only while no command is outstanding.
    always_comb begin
        wr_accept  = wr_en && !req_flag;
        wr_blocked = wr_en && req_flag;
    end

    // Purpose: set on a blocked write (wins over clear), drop on the clear strobe.
    always_ff @(posedge clk) begin
        if (rst_any)         ovr <= 1'b0;
        else if (wr_blocked) ovr <= 1'b1;
        else if (clr)        ovr <= 1'b0;
    end

    assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (rst_any)
        (ovr && !clr) |=> ovr);
    assert_ovr_on_block_R7: assert property (@(posedge clk) disable iff (rst_any)
        (wr_en && req_flag) |=> ovr);
endmodule

// File: rtl/hcv_cmd_flag.sv
// Module: the request flag, set by an accepted host write, cleared by core acknowledge.
// Assumes: ack is a single-cycle pulse; wr_accept never rises while the flag is set.
module hcv_cmd_flag (
    input  logic clk,
    input  logic rst_any,
    input  logic wr_accept,
    input  logic wr_req_bit,
    input  logic ack,
    output logic flag
);
    // Purpose: track the request from host write until core acceptance.
    always_ff @(posedge clk) begin
        if (rst_any)              flag <= 1'b0;
        else if (wr_accept)       flag <= wr_req_bit;
        else if (ack && flag)     flag <= 1'b0;
    end

    assert_ack_clears_R3: assert property (@(posedge clk) disable iff (rst_any)
        (flag && ack) |=> !flag);
    assert_set_on_write_R2: assert property (@(posedge clk) disable iff (rst_any)
        (wr_accept && wr_req_bit) |=> flag);
    assert_idle_ack_R9: assert property (@(posedge clk) disable iff (rst_any)
        (!flag && ack && !wr_accept) |=> !flag);
endmodule

// File: rtl/hcv_vec_store.sv
// Module: holds the vector number and forms the doubled routine address.
// Assumes: writes reach here only when accepted; RST_VEC fits in VEC_W bits.
module hcv_vec_store #(
    parameter int              VEC_W   = hcv_pkg::HCV_VEC_W_DEF,
    parameter logic [VEC_W-1:0] RST_VEC = hcv_pkg::HCV_RST_VEC_DEF,
    localparam int             ADDR_W  = VEC_W + 1
) (
    input  logic              clk,
    input  logic              rst_any,
    input  logic              wr_accept,
    input  logic [VEC_W-1:0]  wr_vec,
    output logic [VEC_W-1:0]  vec,
    output logic [ADDR_W-1:0] addr
);
    // Purpose: latch the vector on an accepted write, reload default on reset.
    always_ff @(posedge clk) begin
        if (rst_any)        vec <= RST_VEC;
        else if (wr_accept) vec <= wr_vec;
    end

    // Purpose: routine address is the vector shifted left by one.
    always_comb begin
        addr = {vec, 1'b0};
    end

    assert_reset_vec_R6: assert property (@(posedge clk)
        rst_any |=> (vec == RST_VEC));
    assert_vec_hold_R7: assert property (@(posedge clk) disable iff (rst_any)
        !wr_accept |=> $stable(vec));
endmodule

// File: rtl/hcv_top.sv
// Module: host command vector handshake register, top level.
// Assumes: single clock domain; all resets synchronous; core_ack is a one-cycle pulse.
module hcv_top #(
    parameter int VEC_W = hcv_pkg::HCV_VEC_W_DEF,
    parameter logic [VEC_W-1:0] RST_VEC = hcv_pkg::HCV_RST_VEC_DEF,
    localparam int DW = VEC_W + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_rst,
    input  logic          ind_rst,
    input  logic          stop_rst,
    input  logic          host_wr_en,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          ovr_err,
    input  logic          ovr_clr,
    output logic          core_req,
    output logic          core_pend,
    output logic [DW-1:0] core_vec_addr,
    input  logic          core_ack
);
    logic             rst_any;
    logic             wr_accept;
    logic             flag;
    logic [VEC_W-1:0] vec;

    hcv_rst_merge u_rst (
        .rst_n(rst_n), .sw_rst(sw_rst), .ind_rst(ind_rst),
        .stop_rst(stop_rst), .rst_any(rst_any)
    );

    hcv_overrun u_ovr (
        .clk(clk), .rst_any(rst_any), .wr_en(host_wr_en), .req_flag(flag),
        .clr(ovr_clr), .wr_accept(wr_accept), .ovr(ovr_err)
    );

    hcv_cmd_flag u_flag (
        .clk(clk), .rst_any(rst_any), .wr_accept(wr_accept),
        .wr_req_bit(host_wdata[DW-1]), .ack(core_ack), .flag(flag)
    );

    hcv_vec_store #(.VEC_W(VEC_W), .RST_VEC(RST_VEC)) u_vec (
        .clk(clk), .rst_any(rst_any), .wr_accept(wr_accept),
        .wr_vec(host_wdata[VEC_W-1:0]), .vec(vec), .addr(core_vec_addr)
    );

    // Purpose: present register image to the host and status to the core.
    always_comb begin
        host_rdata = {flag, vec};
        core_req   = flag;
        core_pend  = flag;
    end

    assert_addr_even_R4: assert property (@(posedge clk) disable iff (rst_any)
        core_vec_addr[DW-1:1] == host_rdata[VEC_W-1:0]);
    assert_dropped_write_R11: assert property (@(posedge clk) disable iff (rst_any)
        (host_wr_en && core_req && core_ack) |=> (!core_req && ovr_err));
endmodule

// File: tb/sim_hcv_top.sv
// Bench: sweeps all vector numbers through the handshake, plus resets and collisions.
module sim_hcv_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0, sw_rst = 1'b0, ind_rst = 1'b0, stop_rst = 1'b0;
    logic       host_wr_en = 1'b0, ovr_clr = 1'b0, core_ack = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata, core_vec_addr;
    logic       ovr_err, core_req, core_pend;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    hcv_top u0 (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .ind_rst(ind_rst),
        .stop_rst(stop_rst), .host_wr_en(host_wr_en), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .ovr_err(ovr_err), .ovr_clr(ovr_clr),
        .core_req(core_req), .core_pend(core_pend),
        .core_vec_addr(core_vec_addr), .core_ack(core_ack)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        host_wr_en = 1'b1; host_wdata = d;
        tick();
        host_wr_en = 1'b0;
    endtask

    task automatic ack();
        core_ack = 1'b1;
        tick();
        core_ack = 1'b0;
    endtask

    task automatic chk_reset(input string tag);
        chk({tag, " R6 rdata"}, host_rdata, 8'h32);
        chk({tag, " R6 addr"}, core_vec_addr, 8'h64);
        chk({tag, " R6 req"}, core_req, 0);
        chk({tag, " R6 ovr"}, ovr_err, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        chk_reset("hw");

        // R9: acknowledge with nothing pending
        ack();
        chk("R9 idle ack rdata", host_rdata, 8'h32);
        chk("R9 idle ack req", core_req, 0);

        for (int v = 0; v < 128; v++) begin
            wr(8'h80 | 8'(v));
            chk("R1 R5 rdata", host_rdata, 8'h80 | v);
            chk("R2 req", core_req, 1);
            chk("R2 pend", core_pend, 1);
            chk("R4 addr", core_vec_addr, 2 * v);
            wr(8'(~v) & 8'h7F);
            chk("R7 rdata held", host_rdata, 8'h80 | v);
            chk("R7 ovr set", ovr_err, 1);
            ovr_clr = 1'b1; tick(); ovr_clr = 1'b0;
            chk("R8 ovr cleared", ovr_err, 0);
            ack();
            chk("R3 rdata", host_rdata, v);
            chk("R3 req", core_req, 0);
            chk("R4 addr after ack", core_vec_addr, 2 * v);
        end

        // R10: vector-only writes
        for (int v = 0; v < 128; v += 5) begin
            wr(8'(v));
            chk("R10 rdata", host_rdata, v);
            chk("R10 req", core_req, 0);
            chk("R10 addr", core_vec_addr, 2 * v);
        end

        // R8: stickiness over idle cycles, then set/clear collision
        wr(8'h91);
        wr(8'h05);
        tick(); tick();
        chk("R8 sticky", ovr_err, 1);
        host_wr_en = 1'b1; host_wdata = 8'h22; ovr_clr = 1'b1;
        tick();
        host_wr_en = 1'b0; ovr_clr = 1'b0;
        chk("R8 set beats clear", ovr_err, 1);
        chk("R7 rdata after collision", host_rdata, 8'h91);
        ovr_clr = 1'b1; tick(); ovr_clr = 1'b0;

        // R11: write and acknowledge in the same cycle
        host_wr_en = 1'b1; host_wdata = 8'hC4; core_ack = 1'b1;
        tick();
        host_wr_en = 1'b0; core_ack = 1'b0;
        chk("R11 req cleared", core_req, 0);
        chk("R11 vec unchanged", host_rdata, 8'h11);
        chk("R11 ovr", ovr_err, 1);

        // R6: each of the three reset strobes from a busy state
        for (int s = 0; s < 3; s++) begin
            wr(8'h85);
            wr(8'h06);
            chk("R7 pre-reset ovr", ovr_err, 1);
            if (s == 0) sw_rst = 1'b1;
            if (s == 1) ind_rst = 1'b1;
            if (s == 2) stop_rst = 1'b1;
            tick();
            sw_rst = 1'b0; ind_rst = 1'b0; stop_rst = 1'b0;
            chk_reset(s == 0 ? "sw" : (s == 1 ? "ind" : "stop"));
        end
        wr(8'h85);
        rst_n = 1'b0; tick(); rst_n = 1'b1;
        chk_reset("hw2");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule